// File: doc/BRIEF.md
# Heartbeat Watchdog Supervisor

This block stands between a group of monitored agents and a system watchdog. Each agent raises its heartbeat input for one cycle whenever it finishes a unit of work. The supervisor keeps a separate count of these beats for every agent. At the end of each check window it compares every count with a minimum. If all agents reached the minimum, it sends one reload pulse to the watchdog. If any agent fell short, it sends nothing, so the watchdog runs out and resets the system.

The window length is a parameter in clock ticks. Its default is 100 ms at a 1 MHz clock. The downstream watchdog should be set to time out about 20% later than the window, so that one missed reload is enough to let it expire. An enable input gates the whole check. While enable is low the supervisor is idle, and each time it is raised a fresh window begins.

Top module: `beat_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `kick` is low. Reset clears every beat count and the window timer.
- R2: While `enable` is high, a check takes place on every CHECK_TICKS-th rising edge. The first check comes on the CHECK_TICKS-th edge after the first edge at which `enable` is sampled high. No kick appears between checks.
- R3: Each source has its own counter. A high `heartbeat[i]` sampled at an edge adds one to source i's count only.
- R4: When every source's count is at least MIN_BEATS at a check, the check passes and produces a kick.
- R5: When any source's count is below MIN_BEATS at a check, the check fails and produces no kick.
- R6: All counts are cleared at every check, whether the check passed or failed.
- R7: A heartbeat sampled at the same edge as a check is not used by that check. It becomes a count of 1 in the next window.
- R8: A count that has reached 2^CNT_W-1 stays there when further beats arrive, instead of wrapping to zero.
- R9: While `enable` is low, no check runs and `kick` stays low. Counts and the timer are held at zero, so beats seen while disabled never count.
- R10: `kick` is a registered pulse. It is high for exactly the one cycle after the edge of a passing check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the checks when high; holds the supervisor idle when low |
| heartbeat | input | NUM_SRC | One single-cycle beat bit per monitored source |
| kick | output | 1 | Single-cycle reload pulse to the watchdog |

## Verification
The bench drives each source exactly at the threshold and one beat below it, one source at a time. A design with an off-by-one compare would kick on a short window or miss a valid one. It places a beat exactly on the check edge and then supplies one beat fewer in the next window. A design that drops or miscounts that beat would fail the second window or wrongly pass the first. Two failing windows of one beat each are run back to back, which catches a design that clears the counts only after a pass. A source is driven past the counter's top value, where wrap-around would turn a pass into a fail. The bench also beats during a disabled interval, which a design that keeps counting while idle would credit to the next window.

// File: rtl/beat_sup_pkg.sv
package beat_sup_pkg;
  // Strobes from the window control to the counting datapath
  typedef struct packed {
    logic hold;      // supervisor idle: keep all counts at zero
    logic checkNow;  // last tick of window: evaluate and reload counts
  } supStrobe_t;
endpackage

// File: rtl/beat_sup_ctrl.sv
module beat_sup_ctrl
  import beat_sup_pkg::*;
#(
  parameter int CHECK_TICKS = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       allMet,
  output supStrobe_t strobe,
  output logic       kick
);
  localparam int TW = (CHECK_TICKS > 1) ? $clog2(CHECK_TICKS) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(CHECK_TICKS - 1);

  logic [TW-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!enable) begin
      tickCnt <= '0;
    end else if (tickCnt == LAST_TICK) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.hold     = !enable;
    strobe.checkNow = enable && (tickCnt == LAST_TICK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) kick <= 1'b0;
    else       kick <= strobe.checkNow && allMet;
  end

  // R2: timer never leaves its window range
  assert_timer_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= LAST_TICK);

  // R9: a disabled cycle never leads to a kick
  assert_no_kick_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !kick);

  // R10: the kick pulse lasts a single cycle
  assert_kick_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !kick);
endmodule

// File: rtl/beat_sup_datapath.sv
module beat_sup_datapath
  import beat_sup_pkg::*;
#(
  parameter int NUM_SRC   = 3,
  parameter int CNT_W     = 8,
  parameter int MIN_BEATS = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] heartbeat,
  input  supStrobe_t         strobe,
  output logic               allMet
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BEATS);

  logic [CNT_W-1:0]   beatCnt [NUM_SRC];
  logic [NUM_SRC-1:0] srcMet;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        beatCnt[g] <= '0;
      end else if (strobe.hold) begin
        beatCnt[g] <= '0;
      end else if (strobe.checkNow) begin
        // a beat on the check edge opens the next window
        beatCnt[g] <= CNT_W'(heartbeat[g]);
      end else if (heartbeat[g] && (beatCnt[g] != CNT_MAX)) begin
        beatCnt[g] <= beatCnt[g] + 1'b1;
      end
    end

    assign srcMet[g] = (beatCnt[g] >= MIN_CNT);

    // R8: a saturated counter stays at its top value within a window
    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.hold && !strobe.checkNow && beatCnt[g] == CNT_MAX) |=> beatCnt[g] == CNT_MAX);

    // R6/R7: after a check, the count holds only the beat from the check edge
    assert_clear_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.hold && strobe.checkNow) |=> beatCnt[g] == CNT_W'($past(heartbeat[g])));

    // R9: counts sit at zero while idle
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobe.hold |=> beatCnt[g] == '0);
  end

  assign allMet = &srcMet;
endmodule

// File: rtl/beat_supervisor.sv
module beat_supervisor
  import beat_sup_pkg::*;
#(
  parameter int NUM_SRC     = 3,
  parameter int CHECK_TICKS = 100000,
  parameter int MIN_BEATS   = 1,
  parameter int CNT_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_SRC-1:0] heartbeat,
  output logic               kick
);
  supStrobe_t strobe;
  logic       allMet;

  beat_sup_ctrl #(
    .CHECK_TICKS(CHECK_TICKS)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .enable(enable),
    .allMet(allMet),
    .strobe(strobe),
    .kick  (kick)
  );

  beat_sup_datapath #(
    .NUM_SRC  (NUM_SRC),
    .CNT_W    (CNT_W),
    .MIN_BEATS(MIN_BEATS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .heartbeat(heartbeat),
    .strobe   (strobe),
    .allMet   (allMet)
  );

  // R4/R5: a kick only follows a cycle where every source met the minimum
  assert_kick_needs_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    kick |-> $past(allMet));
endmodule

// File: tb/sim_beat_supervisor.sv
module sim_beat_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int CHECK      = 20;
  localparam int MINB       = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] hb = '0;
  logic       kick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  beat_supervisor #(
    .NUM_SRC(3), .CHECK_TICKS(CHECK), .MIN_BEATS(MINB), .CNT_W(3)
  ) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .heartbeat(hb), .kick(kick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, 20000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Start a fresh window: one idle cycle, then enable (we sit at a negedge)
  task automatic startFresh();
    enable = 1'b0; hb = '0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  // One full window; n* beats for each source on the first edges,
  // optional extra beat on source 0 at the check edge itself.
  task automatic runWindow(input int n0, input int n1, input int n2,
                           input bit carry, input bit expKick, input string req);
    int early = 0;
    bit firstLow = 1'b1;
    for (int e = 1; e <= CHECK; e++) begin
      hb[0] = ((e <= n0) && (e < CHECK)) || (carry && (e == CHECK));
      hb[1] = (e <= n1) && (e < CHECK);
      hb[2] = (e <= n2) && (e < CHECK);
      @(posedge clk);
      @(negedge clk);
      if (e == 1 && kick) firstLow = 1'b0;
      if (e < CHECK && kick) early++;
    end
    hb = '0;
    chk(firstLow, "R10", "kick high in cycle after its pulse", 1, 0);
    chk(early == 0, "R2", "kicks between checks", early, 0);
    chk(kick == expKick, req, $sformatf("kick at check for beats %0d/%0d/%0d", n0, n1, n2),
        int'(kick), int'(expKick));
  endtask

  task automatic testReset();
    int bad = 0;
    rstN = 1'b0; enable = 1'b1; hb = '1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (kick) bad++;
    end
    enable = 1'b0; hb = '0;
    rstN = 1'b1;
    @(negedge clk);
    if (kick) bad++;
    chk(bad == 0, "R1", "kick during and after reset", bad, 0);
  endtask

  task automatic testPass();
    startFresh();
    runWindow(2, 2, 2, 1'b0, 1'b1, "R4");   // exactly at threshold, R2 first check
    runWindow(3, 5, 2, 1'b0, 1'b1, "R4");
    runWindow(19, 19, 19, 1'b0, 1'b1, "R3");
  endtask

  task automatic testShort();
    runWindow(1, 2, 2, 1'b0, 1'b0, "R5");   // source 0 short
    runWindow(2, 1, 2, 1'b0, 1'b0, "R3");   // source 1 short, others fine
    runWindow(2, 2, 1, 1'b0, 1'b0, "R5");   // source 2 short
    runWindow(0, 0, 0, 1'b0, 1'b0, "R5");
    runWindow(2, 2, 2, 1'b0, 1'b1, "R4");
  endtask

  task automatic testClear();
    runWindow(4, 4, 4, 1'b0, 1'b1, "R4");
    runWindow(0, 0, 0, 1'b0, 1'b0, "R6");   // counts cleared after pass
    runWindow(1, 1, 1, 1'b0, 1'b0, "R5");
    runWindow(1, 1, 1, 1'b0, 1'b0, "R6");   // counts cleared after fail
  endtask

  task automatic testCarry();
    runWindow(1, 2, 2, 1'b1, 1'b0, "R7");   // check-edge beat not used now
    runWindow(1, 2, 2, 1'b0, 1'b1, "R7");   // but it counts in next window
  endtask

  task automatic testSaturate();
    runWindow(9, 2, 2, 1'b0, 1'b1, "R8");   // 9 beats into 3-bit counter
    runWindow(2, 12, 15, 1'b0, 1'b1, "R8");
  endtask

  task automatic testDisable();
    int bad = 0;
    enable = 1'b0; hb = '1;
    for (int i = 0; i < 3 * CHECK; i++) begin
      @(negedge clk);
      if (kick) bad++;
    end
    hb = '0;
    chk(bad == 0, "R9", "kicks while disabled", bad, 0);
    enable = 1'b1;
    runWindow(1, 1, 1, 1'b0, 1'b0, "R9");   // idle beats must not count
    runWindow(2, 2, 2, 1'b0, 1'b1, "R9");
    enable = 1'b0;
    @(negedge clk);
    chk(kick == 1'b0, "R10", "kick one cycle after pulse", int'(kick), 0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testPass();
    testShort();
    testClear();
    testCarry();
    testSaturate();
    testDisable();
    summary();
  end
endmodule